// File: doc/BRIEF.md
# Iterative Integer Divider with Saveable Context

This block is a register-mapped integer divider. Software loads a dividend and a divisor, then collects a quotient and a remainder a fixed number of cycles later. Operands may be loaded through an unsigned or a signed register select. The select used by the most recent operand write decides how the pair is interpreted. Inside, a shift-subtract engine resolves several quotient bits per clock. It works on magnitudes and applies sign correction in its last cycle.

Two status flags let an interrupt handler share the divider with the code it interrupted. READY shows that the result registers hold a finished answer. DIRTY shows that someone has used the divider since the quotient was last read. A handler that finds DIRTY set waits for READY and saves the four data registers. Before returning, it writes them back as dividend, divisor, remainder, quotient. The quotient and remainder registers accept direct writes, so a saved result comes back without running a new division.

The register port is plain and single-cycle. There is no handshake and no back-pressure: every write takes effect at the clock edge that samples it. Read data is combinational from the selected register, and a read's side effect lands at that same edge.

Top module: `iter_divider`

## Requirements
- R1: After reset the status register reads 1 (READY=1, DIRTY=0), and the dividend, divisor, quotient and remainder registers all read 0.
- R2: The register select is a word index, and the byte offset is 4 times the index. The indexes are: 0 unsigned dividend, 1 unsigned divisor, 2 quotient, 3 remainder, 4 signed dividend, 5 signed divisor, 6 status. Status bit 0 is READY and bit 1 is DIRTY. Indexes 4 and 5 read back the same values as 0 and 1. Index 7 reads 0. Writes to indexes 6 and 7 change nothing.
- R3: A write to any of indexes 0, 1, 4 or 5 makes the status read READY=0 and DIRTY=1 from the next cycle on, and restarts the division even if one is running.
- R4: If the last operand write is sampled at edge E0, READY stays 0 through edge E(CYCLES-1) and is 1 after edge E(CYCLES), with both results valid.
- R5: In unsigned mode with a nonzero divisor, the quotient is floor(dividend/divisor) and the remainder is dividend mod divisor.
- R6: In signed mode, the quotient truncates toward zero and a nonzero remainder takes the sign of the dividend. The most negative dividend divided by -1 gives the most negative quotient and remainder 0.
- R7: With a zero divisor, the division finishes in the same latency and the remainder equals the dividend. In unsigned mode the quotient is all ones. In signed mode it is the most positive value for a dividend of 0 or more, and the most negative value otherwise.
- R8: The signedness of a division is taken from the select of the most recent operand write, whichever of the two operands it wrote.
- R9: A quotient write loads the value, sets READY and DIRTY, and cancels any running division, so no later completion overwrites either result register. This holds even when the write lands on the completing edge.
- R10: A remainder write loads the value, leaves READY unchanged, and cancels any running division.
- R11: Reading the quotient clears DIRTY. Reading any other register leaves DIRTY unchanged.
- R12: The restore order (dividend, divisor, remainder, quotient, written back to back) leaves all four registers holding the written values, with READY=1 and DIRTY=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for the selected register |
| bus_rd | input | 1 | Read strobe; matters only for its quotient side effect |
| reg_sel | input | 3 | Word index of the register accessed |
| bus_wdata | input | DW | Write data |
| bus_rdata | output | DW | Read data of the selected register, combinational |

## Verification
A direct result write can fall in the same cycle as the engine's completion. That is the point where saving and restoring context races the divider's own answer. The bench provokes the race by timing a quotient write, and separately a remainder write, to be sampled exactly on the completing edge. It judges the outcome from the status flags and from both result registers read afterwards. The written value must survive, the computed result must be discarded, and READY must be set only by the quotient write. Correct arithmetic is covered separately, by a sweep of every dividend of a narrow configuration against a spread of divisors in both modes.

// File: rtl/iter_divider_pkg.sv
package iter_divider_pkg;
  localparam int SEL_W = 3;
  localparam logic [SEL_W-1:0] SEL_UDVD = 3'd0;
  localparam logic [SEL_W-1:0] SEL_UDVS = 3'd1;
  localparam logic [SEL_W-1:0] SEL_QUO  = 3'd2;
  localparam logic [SEL_W-1:0] SEL_REM  = 3'd3;
  localparam logic [SEL_W-1:0] SEL_SDVD = 3'd4;
  localparam logic [SEL_W-1:0] SEL_SDVS = 3'd5;
  localparam logic [SEL_W-1:0] SEL_STAT = 3'd6;
  localparam int STAT_READY_BIT = 0;
  localparam int STAT_DIRTY_BIT = 1;
endpackage

// File: rtl/idiv_step.sv
// One restoring shift-subtract step: shifts one dividend bit into the
// partial remainder and emits one quotient bit.
module idiv_step #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] shf_i,
  input  logic [DW-1:0] den_i,
  output logic [DW-1:0] acc_o,
  output logic [DW-1:0] shf_o
);
  logic [DW:0] trial;
  logic [DW:0] diff;
  logic        take;

  always_comb begin
    trial = {acc_i, shf_i[DW-1]};
    diff  = trial - {1'b0, den_i};
    take  = ~diff[DW];
    acc_o = take ? diff[DW-1:0] : trial[DW-1:0];
    shf_o = {shf_i[DW-2:0], take};
  end
endmodule

// File: rtl/idiv_fixup.sv
// Converts magnitude results to the final signed/unsigned encoding,
// including the zero-divisor values.
module idiv_fixup #(
  parameter int DW = 32
) (
  input  logic [DW-1:0] qmag_i,
  input  logic [DW-1:0] rmag_i,
  input  logic          sgn_i,
  input  logic          negq_i,
  input  logic          negr_i,
  input  logic          zero_i,
  input  logic          aneg_i,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);
  localparam logic [DW-1:0] SMIN = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] SMAX = {1'b0, {(DW-1){1'b1}}};

  always_comb begin
    if (zero_i) begin
      if (sgn_i) quo_o = aneg_i ? SMIN : SMAX;
      else       quo_o = '1;
    end else begin
      quo_o = negq_i ? (~qmag_i + 1'b1) : qmag_i;
    end
    rem_o = negr_i ? (~rmag_i + 1'b1) : rmag_i;
  end
endmodule

// File: rtl/idiv_engine.sv
// Multi-bit-per-cycle divider engine with fixed latency CYCLES.
module idiv_engine #(
  parameter int DW     = 32,
  parameter int CYCLES = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          signed_i,
  input  logic [DW-1:0] dvd_i,
  input  logic [DW-1:0] dvs_i,
  input  logic          cancel_i,
  output logic          done_o,
  output logic [DW-1:0] quo_o,
  output logic [DW-1:0] rem_o
);
  localparam int SPC = DW / CYCLES;
  localparam int CW  = $clog2(CYCLES + 1);

  logic [CW-1:0] cnt_q;
  logic [DW-1:0] acc_q, shf_q, den_q;
  logic          sgn_q, negq_q, negr_q, zero_q, aneg_q;

  logic          a_neg, b_neg;
  logic [DW-1:0] a_mag, b_mag;

  always_comb begin
    a_neg = signed_i & dvd_i[DW-1];
    b_neg = signed_i & dvs_i[DW-1];
    a_mag = a_neg ? (~dvd_i + 1'b1) : dvd_i;
    b_mag = b_neg ? (~dvs_i + 1'b1) : dvs_i;
  end

  logic [DW-1:0] acc_c [SPC+1];
  logic [DW-1:0] shf_c [SPC+1];

  assign acc_c[0] = acc_q;
  assign shf_c[0] = shf_q;

  for (genvar g = 0; g < SPC; g++) begin : g_step
    idiv_step #(.DW(DW)) u_step (
      .acc_i (acc_c[g]),
      .shf_i (shf_c[g]),
      .den_i (den_q),
      .acc_o (acc_c[g+1]),
      .shf_o (shf_c[g+1])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      acc_q  <= '0;
      shf_q  <= '0;
      den_q  <= '0;
      sgn_q  <= 1'b0;
      negq_q <= 1'b0;
      negr_q <= 1'b0;
      zero_q <= 1'b0;
      aneg_q <= 1'b0;
    end else if (start_i) begin
      cnt_q  <= CW'(CYCLES);
      acc_q  <= '0;
      shf_q  <= a_mag;
      den_q  <= b_mag;
      sgn_q  <= signed_i;
      negq_q <= a_neg ^ b_neg;
      negr_q <= a_neg;
      zero_q <= (dvs_i == '0);
      aneg_q <= a_neg;
    end else if (cancel_i) begin
      cnt_q  <= '0;
    end else if (cnt_q != '0) begin
      acc_q  <= acc_c[SPC];
      shf_q  <= shf_c[SPC];
      cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign done_o = (cnt_q == CW'(1));

  idiv_fixup #(.DW(DW)) u_fixup (
    .qmag_i (shf_c[SPC]),
    .rmag_i (acc_c[SPC]),
    .sgn_i  (sgn_q),
    .negq_i (negq_q),
    .negr_i (negr_q),
    .zero_i (zero_q),
    .aneg_i (aneg_q),
    .quo_o  (quo_o),
    .rem_o  (rem_o)
  );
endmodule

// File: rtl/iter_divider.sv
module iter_divider
  import iter_divider_pkg::*;
#(
  parameter int DW     = 32,
  parameter int CYCLES = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_wr,
  input  logic             bus_rd,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [DW-1:0]    bus_wdata,
  output logic [DW-1:0]    bus_rdata
);
  logic [DW-1:0] dvd_q, dvs_q, quo_q, rem_q;
  logic          rdy_q, dirty_q;

  logic dvd_wr, dvs_wr, op_wr, q_wr, r_wr, q_rd, alias_s;
  logic [DW-1:0] dvd_nx, dvs_nx;
  logic          eng_done;
  logic [DW-1:0] eng_q, eng_r;

  always_comb begin
    dvd_wr  = bus_wr & ((reg_sel == SEL_UDVD) | (reg_sel == SEL_SDVD));
    dvs_wr  = bus_wr & ((reg_sel == SEL_UDVS) | (reg_sel == SEL_SDVS));
    op_wr   = dvd_wr | dvs_wr;
    alias_s = (reg_sel == SEL_SDVD) | (reg_sel == SEL_SDVS);
    q_wr    = bus_wr & (reg_sel == SEL_QUO);
    r_wr    = bus_wr & (reg_sel == SEL_REM);
    q_rd    = bus_rd & ~bus_wr & (reg_sel == SEL_QUO);
    dvd_nx  = dvd_wr ? bus_wdata : dvd_q;
    dvs_nx  = dvs_wr ? bus_wdata : dvs_q;
  end

  idiv_engine #(.DW(DW), .CYCLES(CYCLES)) u_engine (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_i  (op_wr),
    .signed_i (alias_s),
    .dvd_i    (dvd_nx),
    .dvs_i    (dvs_nx),
    .cancel_i (q_wr | r_wr),
    .done_o   (eng_done),
    .quo_o    (eng_q),
    .rem_o    (eng_r)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dvd_q   <= '0;
      dvs_q   <= '0;
      quo_q   <= '0;
      rem_q   <= '0;
      rdy_q   <= 1'b1;
      dirty_q <= 1'b0;
    end else begin
      if (dvd_wr) dvd_q <= bus_wdata;
      if (dvs_wr) dvs_q <= bus_wdata;
      if (op_wr) begin
        rdy_q   <= 1'b0;
        dirty_q <= 1'b1;
      end else if (q_wr) begin
        quo_q   <= bus_wdata;
        rdy_q   <= 1'b1;
        dirty_q <= 1'b1;
      end else if (r_wr) begin
        rem_q   <= bus_wdata;
      end else if (eng_done) begin
        quo_q   <= eng_q;
        rem_q   <= eng_r;
        rdy_q   <= 1'b1;
      end
      if (q_rd) dirty_q <= 1'b0;
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (reg_sel)
      SEL_UDVD, SEL_SDVD: bus_rdata = dvd_q;
      SEL_UDVS, SEL_SDVS: bus_rdata = dvs_q;
      SEL_QUO:            bus_rdata = quo_q;
      SEL_REM:            bus_rdata = rem_q;
      SEL_STAT: begin
        bus_rdata[STAT_READY_BIT] = rdy_q;
        bus_rdata[STAT_DIRTY_BIT] = dirty_q;
      end
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/iter_divider_chk.sv
module iter_divider_chk #(
  parameter int DW     = 32,
  parameter int CYCLES = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          op_wr,
  input logic          q_wr,
  input logic          r_wr,
  input logic          q_rd,
  input logic [DW-1:0] wdata,
  input logic          ready,
  input logic          dirty,
  input logic [DW-1:0] quo,
  input logic [DW-1:0] rem
);
  localparam int SW = $clog2(CYCLES + 2);
  localparam logic [SW-1:0] SAT = SW'(CYCLES + 1);

  logic [SW-1:0] since;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            since <= '0;
    else if (op_wr)        since <= '0;
    else if (since != SAT) since <= since + 1'b1;
  end

  AST_OPWR_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
    op_wr |=> (!ready && dirty)); // R3

  AST_READY_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ready) && !$past(q_wr)) |-> (since == SW'(CYCLES))); // R4

  AST_QWR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (q_wr && !op_wr) |=> (ready && dirty && quo == $past(wdata))); // R9

  AST_RWR_HOLDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    r_wr |=> (rem == $past(wdata) && $stable(ready))); // R10

  AST_QRD_CLEARS_DIRTY: assert property (@(posedge clk) disable iff (!rst_n)
    q_rd |=> !dirty); // R11
endmodule

bind iter_divider iter_divider_chk #(.DW(DW), .CYCLES(CYCLES)) u_chk (
  .clk   (clk),
  .rst_n (rst_n),
  .op_wr (op_wr),
  .q_wr  (q_wr),
  .r_wr  (r_wr),
  .q_rd  (q_rd),
  .wdata (bus_wdata),
  .ready (rdy_q),
  .dirty (dirty_q),
  .quo   (quo_q),
  .rem   (rem_q)
);

// File: tb/iter_divider_bench.sv
module iter_divider_bench;
  localparam int DW  = 8;
  localparam int CYC = 4;
  localparam logic [2:0] UDVD = 3'd0, UDVS = 3'd1, QUO = 3'd2, REM = 3'd3;
  localparam logic [2:0] SDVD = 3'd4, SDVS = 3'd5, STAT = 3'd6, HOLE = 3'd7;
  localparam logic [DW-1:0] DIVS [16] = '{8'd0, 8'd1, 8'd2, 8'd3, 8'd5, 8'd7, 8'd8, 8'd13,
                                          8'd64, 8'd127, 8'd128, 8'd129, 8'd200, 8'd250, 8'd254, 8'd255};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0] reg_sel = '0;
  logic [DW-1:0] bus_wdata = '0;
  logic [DW-1:0] bus_rdata;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  iter_divider #(.DW(DW), .CYCLES(CYC)) u_iter_divider (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .reg_sel(reg_sel), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
  );

  task automatic put(input logic [2:0] a, input logic [DW-1:0] d);
    bus_wr = 1'b1; reg_sel = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic get(input logic [2:0] a, output logic [DW-1:0] d);
    bus_rd = 1'b1; reg_sel = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input string what,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  task automatic expect_reg(input string req, input logic [2:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] v;
    get(a, v);
    check(req, $sformatf("reg %0d", a), v, exp);
  endtask

  function automatic void model(input bit sgn, input logic [DW-1:0] a, input logic [DW-1:0] b,
                                output logic [DW-1:0] q, output logic [DW-1:0] r);
    int sa, sb;
    sa = int'($signed(a));
    sb = int'($signed(b));
    if (!sgn) begin
      if (b == 0) begin q = '1; r = a; end
      else begin q = a / b; r = a % b; end
    end else begin
      if (sb == 0) begin
        q = (sa < 0) ? {1'b1, {(DW-1){1'b0}}} : {1'b0, {(DW-1){1'b1}}};
        r = a;
      end else if (sa == -(1 << (DW-1)) && sb == -1) begin
        q = {1'b1, {(DW-1){1'b0}}};
        r = '0;
      end else begin
        q = DW'(sa / sb);
        r = DW'(sa % sb);
      end
    end
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog (R1..all): actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [DW-1:0] v, eq, er;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R1: reset state
    expect_reg("R1", STAT, 8'h01);
    expect_reg("R1", QUO, 8'h00);
    expect_reg("R1", REM, 8'h00);
    expect_reg("R1", UDVD, 8'h00);
    expect_reg("R1", UDVS, 8'h00);

    // R2: aliases, hole, ignored writes
    put(SDVD, 8'h85);
    expect_reg("R2", UDVD, 8'h85);
    expect_reg("R2", SDVD, 8'h85);
    expect_reg("R2", HOLE, 8'h00);
    idle(CYC + 2);
    put(STAT, 8'h00);
    put(HOLE, 8'hFF);
    expect_reg("R2", STAT, 8'h03);

    // R3: operand write drops READY, raises DIRTY
    put(UDVS, 8'h07);
    expect_reg("R3", STAT, 8'h02);

    // R4 / R5 / R11: latency and flag handling
    put(UDVD, 8'd100);
    put(UDVS, 8'd7);
    for (int k = 0; k < CYC; k++) expect_reg("R4", STAT, 8'h02);
    expect_reg("R4", STAT, 8'h03);
    expect_reg("R5", REM, 8'd2);
    expect_reg("R11", STAT, 8'h03);
    expect_reg("R5", QUO, 8'd14);
    expect_reg("R11", STAT, 8'h01);

    // R8: mode from the latest operand write
    put(SDVD, 8'hF0);
    put(UDVS, 8'h03);
    idle(CYC);
    expect_reg("R8", REM, 8'h00);
    expect_reg("R8", QUO, 8'h50);
    put(UDVD, 8'hF0);
    put(SDVS, 8'h03);
    idle(CYC);
    expect_reg("R8", REM, 8'hFF);
    expect_reg("R8", QUO, 8'hFB);

    // R9: quotient write cancels a running division
    put(UDVD, 8'd100);
    put(UDVS, 8'd7);
    idle(1);
    put(QUO, 8'h5A);
    expect_reg("R9", STAT, 8'h03);
    idle(CYC + 2);
    expect_reg("R9", REM, 8'hFF);
    expect_reg("R9", QUO, 8'h5A);
    expect_reg("R9", STAT, 8'h01);

    // R10: remainder write cancels, READY unchanged
    put(UDVD, 8'd100);
    put(UDVS, 8'd7);
    idle(1);
    put(REM, 8'h33);
    idle(CYC + 2);
    expect_reg("R10", STAT, 8'h02);
    expect_reg("R10", REM, 8'h33);
    expect_reg("R10", QUO, 8'h5A);

    // R12: restore order
    put(UDVD, 8'h11);
    put(UDVS, 8'h22);
    put(REM, 8'h44);
    put(QUO, 8'h33);
    expect_reg("R12", STAT, 8'h03);
    idle(CYC + 2);
    expect_reg("R12", UDVD, 8'h11);
    expect_reg("R12", UDVS, 8'h22);
    expect_reg("R12", REM, 8'h44);
    expect_reg("R12", QUO, 8'h33);
    expect_reg("R12", STAT, 8'h01);

    // R9: quotient write on the completing edge
    put(UDVD, 8'd200);
    put(UDVS, 8'd9);
    idle(CYC - 1);
    put(QUO, 8'hA5);
    expect_reg("R9", STAT, 8'h03);
    idle(3);
    expect_reg("R9", REM, 8'h44);
    expect_reg("R9", QUO, 8'hA5);

    // R10: remainder write on the completing edge
    put(UDVD, 8'd200);
    put(UDVS, 8'd9);
    idle(CYC - 1);
    put(REM, 8'h5C);
    expect_reg("R10", STAT, 8'h02);
    idle(3);
    expect_reg("R10", REM, 8'h5C);
    expect_reg("R10", QUO, 8'hA5);

    // R5 / R6 / R7: sweep every dividend against a divisor spread, both modes
    for (int m = 0; m < 2; m++) begin
      for (int j = 0; j < 16; j++) begin
        for (int i = 0; i < 256; i++) begin
          put(m ? SDVD : UDVD, DW'(i));
          put(m ? SDVS : UDVS, DIVS[j]);
          idle(CYC);
          model(m != 0, DW'(i), DIVS[j], eq, er);
          get(REM, v);
          check((DIVS[j] == 0) ? "R7" : (m ? "R6" : "R5"),
                $sformatf("rem %0h/%0h", i, DIVS[j]), v, er);
          get(QUO, v);
          check((DIVS[j] == 0) ? "R7" : (m ? "R6" : "R5"),
                $sformatf("quo %0h/%0h", i, DIVS[j]), v, eq);
        end
      end
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule